// File: doc/BRIEF.md
# Serial EEPROM Hub Configuration Loader

After reset this block reads a short configuration image from an external three-wire serial EEPROM that is addressed by byte. It reads bytes 0 through 8 in ascending order, one read frame per byte. It then checks the image with an additive checksum and a range check on the port count. If both checks pass, it presents the stored vendor ID, product ID, downstream port count, non-removable port mask and maximum-power byte. If either check fails, it presents built-in defaults instead. When no EEPROM is fitted, the data line floats high, so every byte reads as FFh. The checksum then fails and the defaults are used.

The block runs once after each reset. It raises a one-cycle done strobe when the configuration is final and then leaves the serial bus idle for good. The serial lines are shared with the amber status LEDs, so the block also tells the LED logic when amber drive may resume. Amber drive is allowed only after loading has finished and only if the EEPROM contents were rejected or absent.

Top module: `eeprom_cfg_loader`

## Requirements
- R1: Each read frame sends, MSB first on the data-in line, a start bit 1, the opcode bits 1 then 0, and the 7-bit byte address. Chip select stays high for the whole frame. The block then samples 8 data bits, MSB first, from data-out at each rising edge of the serial clock. Exactly 9 frames are issued, with addresses 0 through 8 in order.
- R2: Between frames, chip select stays low for at least one serial-clock period. While chip select is low, the serial clock and data-in are both low.
- R3: The image is accepted only if byte 4 equals (byte0 + byte1 + byte2 + byte3 + 1) modulo 256.
- R4: The image is accepted only if byte 7 lies in the range 1 to 4. With a valid checksum, a value of 0, 5 or more causes the defaults to be used.
- R5: When the image is accepted, the outputs are as follows, and use_ee_o is 1:
  - vid_o = {byte1, byte0} and pid_o = {byte3, byte2};
  - port_cnt_o = byte7, and nonrem_o = byte6 bits 3:0, where bit 0 is port 1 and a 1 means non-removable;
  - max_pwr_o = byte8, in 2 mA units.
  Bits 7:4 of byte 6 have no effect.
- R6: When the image is rejected, or no EEPROM is fitted, the outputs are the defaults and use_ee_o is 0. The defaults are: VID and PID from the parameters, 4 ports, mask 0, and maximum power 32h (100 mA).
- R7: done_o pulses high for exactly one cycle. The pulse occurs 9 × 19 × 2 × HALF_DIV cycles after reset release, and the outputs take their final values in that same cycle. After the pulse, chip select stays low and the outputs do not change.
- R8: amber_en_o stays low while loading. After done it equals the inverse of use_ee_o.
- R9: During reset, chip select, the serial clock, data-in and done are all low, and the outputs hold their defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ee_do_i | input | 1 | EEPROM serial data out |
| ee_cs_o | output | 1 | EEPROM chip select |
| ee_sk_o | output | 1 | EEPROM serial clock |
| ee_di_o | output | 1 | EEPROM serial data in |
| vid_o | output | 16 | Vendor ID |
| pid_o | output | 16 | Product ID |
| port_cnt_o | output | 3 | Downstream port count |
| nonrem_o | output | 4 | Non-removable mask, bit 0 = port 1 |
| max_pwr_o | output | 8 | Maximum power, 2 mA units |
| use_ee_o | output | 1 | EEPROM image accepted |
| amber_en_o | output | 1 | Amber LED drive permitted |
| done_o | output | 1 | One-cycle load-complete strobe |

## Verification
A serial clock half-period lasts HALF_DIV system cycles, so each frame lasts 19 × 2 × HALF_DIV cycles. The done strobe and the final outputs are due together at cycle 9 × 19 × 2 × HALF_DIV after reset release. The bench counts cycles from the reset-release edge and requires done at exactly that count, sampling on the falling clock edge. It then checks the outputs in that same sample and checks that done has fallen one sample later. A behavioural EEPROM model shifts out each data bit at the falling serial-clock edge that precedes the rising edge where the block samples it. The model also records every command frame and measures every chip-select-low gap.

// File: rtl/eeprom_cfg_loader.sv
module eeprom_cfg_loader #(
  parameter int HALF_DIV = 2,
  parameter logic [15:0] DEF_VID = 16'h1234,
  parameter logic [15:0] DEF_PID = 16'h5678
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ee_do_i,
  output logic        ee_cs_o,
  output logic        ee_sk_o,
  output logic        ee_di_o,
  output logic [15:0] vid_o,
  output logic [15:0] pid_o,
  output logic [2:0]  port_cnt_o,
  output logic [3:0]  nonrem_o,
  output logic [7:0]  max_pwr_o,
  output logic        use_ee_o,
  output logic        amber_en_o,
  output logic        done_o
);
  localparam int NBYTES   = 9;
  localparam int CMD_BITS = 10;
  localparam int SLOTS    = CMD_BITS + 8 + 1;
  localparam int CW       = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] CNT_LAST  = CW'(HALF_DIV - 1);
  localparam logic [4:0]    SLOT_LAST = 5'(SLOTS - 1);
  localparam logic [4:0]    RD_FIRST  = 5'(CMD_BITS);
  localparam logic [4:0]    RD_LAST   = 5'(CMD_BITS + 7);
  localparam logic [3:0]    IDX_LAST  = 4'(NBYTES - 1);

  logic          busy, ph;
  logic [CW-1:0] cnt;
  logic [4:0]    slot;
  logic [3:0]    idx;
  logic [7:0]    shreg;
  logic [7:0]    b_vl, b_vh, b_pl, b_ph, b_ck, b_port, b_pwr;
  logic [3:0]    b_mask;

  wire [CMD_BITS-1:0] cmd    = {3'b110, 3'b000, idx};
  wire [CMD_BITS-1:0] cmd_sh = cmd << slot;
  wire [7:0] csum_calc = b_vl + b_vh + b_pl + b_ph + 8'd1;
  wire       img_ok    = (csum_calc == b_ck) && (b_port >= 8'd1) && (b_port <= 8'd4);
  wire       half_end  = (cnt == CNT_LAST);

  assign ee_cs_o    = busy && !rst && (slot != SLOT_LAST);
  assign ee_sk_o    = ee_cs_o && ph;
  assign ee_di_o    = ee_cs_o && (slot < RD_FIRST) && cmd_sh[CMD_BITS-1];
  assign amber_en_o = !busy && !use_ee_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b1; ph <= 1'b0; cnt <= '0; slot <= '0; idx <= '0; shreg <= '0;
      done_o <= 1'b0; use_ee_o <= 1'b0;
      vid_o <= DEF_VID; pid_o <= DEF_PID; port_cnt_o <= 3'd4;
      nonrem_o <= 4'd0; max_pwr_o <= 8'h32;
    end else begin
      done_o <= 1'b0;
      if (busy) begin
        if (!half_end) begin
          cnt <= cnt + 1'b1;
        end else begin
          cnt <= '0;
          ph  <= ~ph;
          if (!ph && slot >= RD_FIRST && slot <= RD_LAST)
            shreg <= {shreg[6:0], ee_do_i};
          if (ph) begin
            if (slot == RD_LAST) begin
              case (idx)
                4'd0: b_vl   <= shreg;
                4'd1: b_vh   <= shreg;
                4'd2: b_pl   <= shreg;
                4'd3: b_ph   <= shreg;
                4'd4: b_ck   <= shreg;
                4'd6: b_mask <= shreg[3:0];
                4'd7: b_port <= shreg;
                4'd8: b_pwr  <= shreg;
                default: ;
              endcase
            end
            if (slot == SLOT_LAST) begin
              slot <= '0;
              if (idx == IDX_LAST) begin
                busy   <= 1'b0;
                done_o <= 1'b1;
                if (img_ok) begin
                  use_ee_o   <= 1'b1;
                  vid_o      <= {b_vh, b_vl};
                  pid_o      <= {b_ph, b_pl};
                  port_cnt_o <= b_port[2:0];
                  nonrem_o   <= b_mask;
                  max_pwr_o  <= b_pwr;
                end
              end else begin
                idx <= idx + 1'b1;
              end
            end else begin
              slot <= slot + 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/eeprom_cfg_loader_chk.sv
module eeprom_cfg_loader_chk #(
  parameter logic [15:0] DEF_VID = 16'h1234,
  parameter logic [15:0] DEF_PID = 16'h5678
) (
  input logic        clk,
  input logic        rst,
  input logic        cs,
  input logic        sk,
  input logic        di,
  input logic [15:0] vid,
  input logic [15:0] pid,
  input logic [2:0]  port_cnt,
  input logic [3:0]  nonrem,
  input logic [7:0]  max_pwr,
  input logic        use_ee,
  input logic        amber_en,
  input logic        done
);
  logic seen_done;
  always_ff @(posedge clk) begin
    if (rst) seen_done <= 1'b0;
    else if (done) seen_done <= 1'b1;
  end

  p_sk_needs_cs_r2: assert property (@(posedge clk) disable iff (rst) sk |-> cs);
  p_di_idle_r2: assert property (@(posedge clk) disable iff (rst) !cs |-> !di);
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  p_done_once_r7: assert property (@(posedge clk) disable iff (rst) seen_done |-> !done);
  p_bus_quiet_r7: assert property (@(posedge clk) disable iff (rst) seen_done |-> !cs);
  p_out_stable_r7: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable({vid, pid, port_cnt, nonrem, max_pwr, use_ee}));
  p_port_range_r4: assert property (@(posedge clk) disable iff (rst)
    use_ee |-> (port_cnt >= 3'd1 && port_cnt <= 3'd4));
  p_defaults_r6: assert property (@(posedge clk) disable iff (rst)
    !use_ee |-> (vid == DEF_VID && pid == DEF_PID && port_cnt == 3'd4 &&
                 nonrem == 4'd0 && max_pwr == 8'h32));
  p_amber_r8: assert property (@(posedge clk) disable iff (rst)
    amber_en |-> (!use_ee && (seen_done || done)));
endmodule

bind eeprom_cfg_loader eeprom_cfg_loader_chk #(.DEF_VID(DEF_VID), .DEF_PID(DEF_PID)) u_chk (
  .clk(clk), .rst(rst), .cs(ee_cs_o), .sk(ee_sk_o), .di(ee_di_o),
  .vid(vid_o), .pid(pid_o), .port_cnt(port_cnt_o), .nonrem(nonrem_o),
  .max_pwr(max_pwr_o), .use_ee(use_ee_o), .amber_en(amber_en_o), .done(done_o)
);

// File: tb/tb_eeprom_cfg_loader.sv
module tb_eeprom_cfg_loader;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 2;
  localparam logic [15:0] DV = 16'h1234;
  localparam logic [15:0] DP = 16'h5678;
  localparam int LAT = 9 * 19 * 2 * HALF;

  logic clk = 1'b0, rst = 1'b1, ee_do = 1'b1;
  logic ee_cs, ee_sk, ee_di, use_ee, amber_en, done;
  logic [15:0] vid, pid;
  logic [2:0] port_cnt;
  logic [3:0] nonrem;
  logic [7:0] max_pwr;

  eeprom_cfg_loader #(.HALF_DIV(HALF), .DEF_VID(DV), .DEF_PID(DP)) dut (
    .clk(clk), .rst(rst), .ee_do_i(ee_do), .ee_cs_o(ee_cs), .ee_sk_o(ee_sk),
    .ee_di_o(ee_di), .vid_o(vid), .pid_o(pid), .port_cnt_o(port_cnt),
    .nonrem_o(nonrem), .max_pwr_o(max_pwr), .use_ee_o(use_ee),
    .amber_en_o(amber_en), .done_o(done));

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0;
  int total_cyc = 0;

  logic [7:0] mem [128];
  logic present = 1'b0;
  int bitcnt = 0, reads = 0, frame_err = 0, gap = 0, gap_err = 0;
  logic [9:0] cmdsh = '0;
  logic prev_cs = 1'b0;

  always @(posedge ee_sk) begin
    if (ee_cs) begin
      if (bitcnt < 10) cmdsh = {cmdsh[8:0], ee_di};
      bitcnt = bitcnt + 1;
    end
  end

  always @(negedge ee_sk) begin
    if (ee_cs && bitcnt >= 10 && bitcnt < 18)
      ee_do = present ? mem[cmdsh[6:0]][17 - bitcnt] : 1'b1;
  end

  always @(negedge ee_cs) begin
    if (!rst) begin
      if (bitcnt != 18 || cmdsh[9:7] != 3'b110 || int'(cmdsh[6:0]) != reads) frame_err++;
      reads++;
    end
    bitcnt = 0;
    ee_do = 1'b1;
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (ee_cs) begin
        if (!prev_cs && reads > 0 && gap < 2 * HALF) gap_err++;
        gap = 0;
      end else gap++;
      if (!ee_cs && (ee_sk || ee_di)) gap_err++;
    end
    prev_cs = ee_cs;
  end

  always @(posedge clk) begin
    total_cyc++;
    if (total_cyc > 190000) begin
      fails++; tests++;
      $display("FAIL watchdog R7: act=hung exp=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic set_img(input logic [15:0] v, input logic [15:0] p, input logic [7:0] mask,
                         input logic [7:0] port, input logic [7:0] pwr, input logic [7:0] adj);
    for (int i = 0; i < 128; i++) mem[i] = 8'h5A ^ 8'(i * 7);
    mem[0] = v[7:0]; mem[1] = v[15:8]; mem[2] = p[7:0]; mem[3] = p[15:8];
    mem[4] = v[7:0] + v[15:8] + p[7:0] + p[15:8] + 8'd1 + adj;
    mem[6] = mask; mem[7] = port; mem[8] = pwr;
  endtask

  task automatic run_case(input string name);
    logic ok;
    int cyc;
    logic amber_bad;
    logic [15:0] ev, ep;
    logic [2:0] ec;
    logic [3:0] em;
    logic [7:0] ew, sum;
    sum = mem[0] + mem[1] + mem[2] + mem[3] + 8'd1;
    ok = present && (sum == mem[4]) && mem[7] >= 8'd1 && mem[7] <= 8'd4;
    ev = ok ? {mem[1], mem[0]} : DV;
    ep = ok ? {mem[3], mem[2]} : DP;
    ec = ok ? mem[7][2:0] : 3'd4;
    em = ok ? mem[6][3:0] : 4'd0;
    ew = ok ? mem[8] : 8'h32;
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    reads = 0; frame_err = 0; gap_err = 0; gap = 0; bitcnt = 0;
    chk(!ee_cs && !ee_sk && !ee_di && !done && vid == DV && port_cnt == 3'd4,
        {"R9 reset ", name}, {ee_cs, ee_sk, ee_di, done}, 0);
    rst = 1'b0;
    cyc = 0; amber_bad = 1'b0;
    do begin
      @(negedge clk); cyc++;
      if (!done && amber_en) amber_bad = 1'b1;
    end while (!done && cyc < LAT + 200);
    chk(done && cyc == LAT, {"R7 latency ", name}, cyc, LAT);
    chk(!amber_bad, {"R8 amber during load ", name}, amber_bad, 0);
    chk(use_ee == ok, {"R3 R4 accept ", name}, use_ee, ok);
    chk(vid == ev && pid == ep, {"R5 R6 ids ", name}, {vid, pid}, {ev, ep});
    chk(port_cnt == ec && nonrem == em && max_pwr == ew, {"R5 R6 fields ", name},
        {port_cnt, nonrem, max_pwr}, {ec, em, ew});
    @(negedge clk);
    chk(!done, {"R7 pulse ", name}, done, 0);
    chk(amber_en == !ok, {"R8 amber after ", name}, amber_en, !ok);
    repeat (100) @(negedge clk);
    chk(!ee_cs && vid == ev && max_pwr == ew, {"R7 idle ", name}, ee_cs, 0);
    chk(reads == 9 && frame_err == 0, {"R1 frames ", name}, reads * 256 + frame_err, 9 * 256);
    chk(gap_err == 0, {"R2 gap ", name}, gap_err, 0);
  endtask

  initial begin
    present = 1'b0;
    set_img(16'h0, 16'h0, 0, 0, 0, 0);
    run_case("absent R6");
    present = 1'b1;
    for (int m = 0; m < 16; m++) begin
      set_img(16'h1000 + 16'(m * 16'h0111), 16'hA000 + 16'(m * 16'h0203),
              {4'(m ^ 4'hA), 4'(m)}, 8'((m % 4) + 1), (m == 15) ? 8'hFA : 8'(m * 16), 0);
      run_case($sformatf("valid R5 m=%0d", m));
    end
    set_img(16'h0, 16'h0, 8'h0F, 8'd4, 8'h00, 0);
    run_case("zero ids R5");
    set_img(16'hFFFF, 16'hFFFF, 8'h0F, 8'd4, 8'hFA, 0);
    run_case("csum wrap R3");
    set_img(16'hBEEF, 16'hCAFE, 8'h03, 8'd2, 8'h10, 8'd1);
    run_case("csum plus one R3");
    set_img(16'hBEEF, 16'hCAFE, 8'h03, 8'd2, 8'h10, 8'hFF);
    run_case("csum missing inc R3");
    set_img(16'h2222, 16'h3333, 8'h01, 8'd0, 8'h20, 0);
    run_case("port 0 R4");
    set_img(16'h2222, 16'h3333, 8'h01, 8'd5, 8'h20, 0);
    run_case("port 5 R4");
    set_img(16'h2222, 16'h3333, 8'h01, 8'd8, 8'h20, 0);
    run_case("port 8 R4");
    set_img(16'h2222, 16'h3333, 8'h01, 8'hFF, 8'h20, 0);
    run_case("port FF R4");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule